// File: doc/BRIEF.md
# Clock Buffer Start-up Lock Sequencer

This block gates the outputs of a clock buffer during start-up. It runs on a free-running reference clock and watches four things: a power-good level, an active-low powerdown level, the lock indication of the buffer's PLL, and the buffer's input clock itself. The input clock is sampled into the reference domain and its rising edges are counted over fixed windows. The PLL lock indication must stay high for a set number of reference cycles before it is trusted.

When power is good, powerdown is released, the input clock is seen and the PLL has been steadily locked, the block raises its lock status flag and its output-enable in the same reference cycle. From then on the flag is sticky. It ignores the PLL lock input and the input clock, and it clears only when power-good falls or powerdown is asserted. Either of those two conditions resets the sequencer at once to its idle state with the outputs disabled. All pins are plain levels with no handshake. The block has no data path, so no valid/ready interface applies.

Top module: `startup_lock_seq`

## Requirements
- R1: While `pwr_good` is 0 or `pwr_down_n` is 0, `lock_out` and `clk_oe` are 0, with no wait for a reference clock edge.
- R2: If `src_clk` does not toggle, `lock_out` and `clk_oe` stay 0 whatever `pll_lock_in` does.
- R3: The input clock counts as present only when at least EDGE_MIN rising edges of `src_clk` arrive within one window of WIN_CYC reference cycles. The default is 4 edges in 64 cycles. A clock giving fewer edges per window never leads to lock.
- R4: The PLL counts as stable only after `pll_lock_in` has been continuously 1 for STABLE_CYC reference cycles (default 32). Any 0 restarts that count, so a lock input that drops at least every 20 cycles never leads to lock.
- R5: `lock_out` and `clk_oe` rise in the same reference cycle and are always equal.
- R6: Once `lock_out` is 1, it stays 1 when `pll_lock_in` goes to 0 and when `src_clk` stops.
- R7: `lock_out` clears when `pwr_down_n` goes to 0 and when `pwr_good` goes to 0. After both return to 1, the full sequence runs again and lock can be regained.
- R8: Lock cannot come before the end of the first detection window after reset release. Once the clock is present and `pll_lock_in` is steadily 1, lock follows within LOCK_LIMIT_CYC reference cycles, the start-up limit. With a steady clock and PLL from release, lock occurs by 2*WIN_CYC+STABLE_CYC+8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all timing |
| pwr_good | input | 1 | Power valid level, 0 resets the sequencer asynchronously |
| pwr_down_n | input | 1 | Active-low powerdown, 0 resets the sequencer asynchronously |
| pll_lock_in | input | 1 | PLL lock indication, asynchronous to `ref_clk` |
| src_clk | input | 1 | Buffer input clock being monitored |
| lock_out | output | 1 | Sticky lock status flag |
| clk_oe | output | 1 | Output enable for the buffer's clock drivers |

## Verification
The main path is tried with input clocks at several rates: fast, moderate, and slow enough to fall below the edge threshold. The absent-clock case shows that detection is based on counted edges and not on a level. The PLL input is tried steady high, held low, and dropping every 20 cycles, which separates a continuous-stability filter from a plain level check. Directed sequences then remove the PLL lock and the input clock after lock to show the flag is sticky. They also pull powerdown and power-good separately to show the asynchronous clear, followed by a fresh lock.

// File: rtl/slq_pkg.sv
package slq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE        = 2'd0,
    SQ_WAIT_CLK    = 2'd1,
    SQ_WAIT_STABLE = 2'd2,
    SQ_LOCKED      = 2'd3
  } sq_state_t;
endpackage

// File: rtl/slq_edge_sync.sv
module slq_edge_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_out,
  output logic rise_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], async_in};
  end

  assign level_out = sh_q[STAGES-2];
  assign rise_out  = sh_q[STAGES-2] & ~sh_q[STAGES-1];
endmodule

// File: rtl/slq_clk_detect.sv
module slq_clk_detect #(
  parameter int EDGE_MIN = 4,
  parameter int WIN_CYC  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_pulse,
  output logic present
);
  localparam int WW = $clog2(WIN_CYC);
  localparam int EW = $clog2(EDGE_MIN + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);
  localparam logic [EW-1:0] EDGE_SAT = EW'(EDGE_MIN);

  logic [WW-1:0] win_q;
  logic [EW-1:0] edges_q;
  logic [EW-1:0] edges_nx;
  logic          win_end;

  always_comb begin
    edges_nx = edges_q;
    if (edge_pulse && edges_q != EDGE_SAT) edges_nx = edges_q + 1'b1;
  end

  assign win_end = (win_q == WIN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      edges_q <= '0;
      present <= 1'b0;
    end else if (win_end) begin
      win_q   <= '0;
      edges_q <= '0;
      present <= (edges_nx == EDGE_SAT);
    end else begin
      win_q   <= win_q + 1'b1;
      edges_q <= edges_nx;
    end
  end

  // R3
  present_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != WIN_LAST) |=> $stable(present));
endmodule

// File: rtl/slq_stable_filter.sv
module slq_stable_filter #(
  parameter int STABLE_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_level,
  output logic stable
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(STABLE_CYC);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!lock_level)    run_q <= '0;
    else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
  end

  assign stable = (run_q == CNT_MAX);

  // R4
  drop_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_level |=> !stable);
endmodule

// File: rtl/slq_fsm.sv
module slq_fsm
  import slq_pkg::*;
#(
  parameter int LOCK_LIMIT_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_present,
  input  logic pll_level,
  input  logic pll_stable,
  output logic lock_flag,
  output logic oe
);
  localparam int LW = $clog2(LOCK_LIMIT_CYC + 1);

  sq_state_t st_q, st_nx;
  logic      grant;

  always_comb begin
    st_nx = st_q;
    case (st_q)
      SQ_IDLE:        st_nx = SQ_WAIT_CLK;
      SQ_WAIT_CLK:    if (clk_present) st_nx = SQ_WAIT_STABLE;
      SQ_WAIT_STABLE: begin
        if (!clk_present)    st_nx = SQ_WAIT_CLK;
        else if (pll_stable) st_nx = SQ_LOCKED;
      end
      default:        st_nx = SQ_LOCKED;
    endcase
  end

  assign grant = (st_q == SQ_WAIT_STABLE) && clk_present && pll_stable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      lock_flag <= 1'b0;
      oe        <= 1'b0;
    end else begin
      st_q      <= st_nx;
      lock_flag <= lock_flag | grant;
      oe        <= oe | grant;
    end
  end

  // start-up limit watch: cycles spent with clock present and PLL high but unlocked
  logic [LW-1:0] wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else if (clk_present && pll_level && !lock_flag) begin
      if (wait_q != LW'(LOCK_LIMIT_CYC)) wait_q <= wait_q + 1'b1;
    end else wait_q <= '0;
  end

  // R5
  oe_matches_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe == lock_flag);

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag |=> lock_flag);

  // R2
  lock_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flag) |-> $past(clk_present));

  // R4
  lock_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flag) |-> $past(pll_stable));

  // R8
  startup_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q < LW'(LOCK_LIMIT_CYC));
endmodule

// File: rtl/startup_lock_seq.sv
module startup_lock_seq #(
  parameter int EDGE_MIN       = 4,
  parameter int WIN_CYC        = 64,
  parameter int STABLE_CYC     = 32,
  parameter int LOCK_LIMIT_CYC = 50000,
  parameter int SYNC_STAGES    = 3
) (
  input  logic ref_clk,
  input  logic pwr_good,
  input  logic pwr_down_n,
  input  logic pll_lock_in,
  input  logic src_clk,
  output logic lock_out,
  output logic clk_oe
);
  logic seq_rst_n;
  logic src_rise;
  logic src_lvl;
  logic pll_lvl;
  logic pll_unused_rise;
  logic present;
  logic stable;

  assign seq_rst_n = pwr_good & pwr_down_n;

  slq_edge_sync #(.STAGES(SYNC_STAGES)) u_src_sync (
    .clk(ref_clk), .rst_n(seq_rst_n), .async_in(src_clk),
    .level_out(src_lvl), .rise_out(src_rise)
  );

  slq_edge_sync #(.STAGES(SYNC_STAGES)) u_pll_sync (
    .clk(ref_clk), .rst_n(seq_rst_n), .async_in(pll_lock_in),
    .level_out(pll_lvl), .rise_out(pll_unused_rise)
  );

  slq_clk_detect #(.EDGE_MIN(EDGE_MIN), .WIN_CYC(WIN_CYC)) u_detect (
    .clk(ref_clk), .rst_n(seq_rst_n), .edge_pulse(src_rise), .present(present)
  );

  slq_stable_filter #(.STABLE_CYC(STABLE_CYC)) u_stable (
    .clk(ref_clk), .rst_n(seq_rst_n), .lock_level(pll_lvl), .stable(stable)
  );

  slq_fsm #(.LOCK_LIMIT_CYC(LOCK_LIMIT_CYC)) u_fsm (
    .clk(ref_clk), .rst_n(seq_rst_n), .clk_present(present),
    .pll_level(pll_lvl), .pll_stable(stable),
    .lock_flag(lock_out), .oe(clk_oe)
  );

  // R1
  reset_clears_chk: assert property (@(posedge ref_clk)
    !seq_rst_n |-> (!lock_out && !clk_oe));

  logic unused_ok;
  assign unused_ok = src_lvl ^ pll_unused_rise;
endmodule

// File: tb/startup_lock_seq_bench.sv
`timescale 1ns/1ps
module startup_lock_seq_bench;
  localparam int WIN = 64;
  localparam int STB = 32;
  localparam int NVEC = 7;
  localparam int RUN = 300;
  // half period of src_clk in ns (0 = no clock), PLL mode (0 low, 1 high, 2 drops every 20), expected lock
  localparam int V_HALF [NVEC] = '{100, 0, 240, 100, 100, 60, 30};
  localparam int V_MODE [NVEC] = '{1, 1, 1, 0, 2, 1, 1};
  localparam int V_EXP  [NVEC] = '{1, 0, 0, 0, 0, 1, 1};

  logic ref_clk = 0, pwr_good = 0, pwr_down_n = 1, pll_lock_in = 0, src_clk = 0;
  logic lock_out, clk_oe;
  int src_half = 0;
  int checks = 0, failures = 0;
  int first_lock, mism;
  bit done = 0;

  startup_lock_seq u_startup_lock_seq (
    .ref_clk(ref_clk), .pwr_good(pwr_good), .pwr_down_n(pwr_down_n),
    .pll_lock_in(pll_lock_in), .src_clk(src_clk),
    .lock_out(lock_out), .clk_oe(clk_oe)
  );

  always #10 ref_clk = ~ref_clk;

  always begin
    if (src_half == 0) begin src_clk = 0; #10; end
    else begin #(src_half); src_clk = ~src_clk; end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic run(input int n, input int mode);
    for (int c = 0; c < n; c++) begin
      @(negedge ref_clk);
      pll_lock_in = (mode == 1) || (mode == 2 && (c % 20) != 19);
      if (lock_out !== clk_oe) mism++;
      if (lock_out === 1'b1 && first_lock < 0) first_lock = c;
    end
  endtask

  task automatic power_cycle();
    @(negedge ref_clk);
    pwr_good = 0; pll_lock_in = 0;
    #1;
    @(negedge ref_clk);
    pwr_good = 1; pwr_down_n = 1;
    first_lock = -1; mism = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge ref_clk);
    check("R1 lock in reset", lock_out, 0);
    check("R1 oe in reset", clk_oe, 0);

    for (int v = 0; v < NVEC; v++) begin
      src_half = V_HALF[v];
      power_cycle();
      run(RUN, V_MODE[v]);
      check($sformatf("R2/R3/R4 vec%0d final lock", v), lock_out, V_EXP[v]);
      check($sformatf("R5 vec%0d oe==lock", v), mism, 0);
      if (V_EXP[v] == 1) begin
        check($sformatf("R8 vec%0d not before window", v), int'(first_lock >= WIN - 4), 1);
        check($sformatf("R8 vec%0d within bound", v), int'(first_lock >= 0 && first_lock <= 2*WIN + STB + 8), 1);
      end
    end

    // R6 sticky against PLL drop and clock loss
    src_half = 100;
    power_cycle();
    run(RUN, 1);
    check("R6 locked before drop", lock_out, 1);
    run(100, 0);
    check("R6 lock held after PLL drop", lock_out, 1);
    src_half = 0;
    run(200, 0);
    check("R6 lock held after clock loss", lock_out, 1);
    check("R5 oe held after clock loss", clk_oe, 1);

    // R7 powerdown clears asynchronously, then relock
    #3; pwr_down_n = 0; #1;
    check("R7 powerdown clears lock", lock_out, 0);
    check("R1 powerdown clears oe", clk_oe, 0);
    src_half = 100;
    run(50, 1);
    check("R1 stays low in powerdown", lock_out, 0);
    @(negedge ref_clk); pwr_down_n = 1; first_lock = -1;
    run(RUN, 1);
    check("R7 relock after powerdown", lock_out, 1);

    // R7 power loss clears
    #3; pwr_good = 0; #1;
    check("R7 power loss clears lock", lock_out, 0);
    @(negedge ref_clk); pwr_good = 1;
    run(WIN - 8, 1);
    check("R8 no lock early after power return", lock_out, 0);
    run(RUN, 1);
    check("R7 relock after power return", lock_out, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule